// File: doc/BRIEF.md
# Decimal-Modulus Rate Pulse Generator

This block emits a train of one-cycle pulses whose average rate, in pulses per second, equals the unsigned number on its rate input. Inside is a signed phase accumulator whose modulus is the master clock frequency in hertz, given as a parameter, instead of a power of two. The rate word therefore needs no conversion: writing 9600 to a block clocked at the frequency `CLK_HZ` gives 9600 pulses in every `CLK_HZ` clock cycles.

Each clock, the accumulator sign decides whether a wrap occurs. A negative accumulator raises the registered pulse and receives the modulus minus the rate in a single step. A non-negative accumulator loses the rate. Divide ratios that are not integers give pulse spacing that alternates between the two nearest whole cycle counts. Rates above half the clock give pulses on consecutive cycles.

Top module: `rate_pulse_gen`

## Requirements
- R1: While `rst_ni` is low, the accumulator is held at zero and `pulse_o` is 0.
- R2: For any rate of at most `CLK_HZ`/2, every pulse on `pulse_o` is exactly one clock cycle wide.
- R3: With a constant legal rate M (0 ≤ M < `CLK_HZ`), every window of exactly `CLK_HZ` cycles counted from the first clock edge after reset holds exactly M pulses. A rate at or above `CLK_HZ` is illegal and is reported by a run-time check.
- R4: With a constant rate M > 0, the distance between two consecutive pulses is always floor(`CLK_HZ`/M) or ceil(`CLK_HZ`/M) cycles.
- R5: A rate of 0 gives no pulses.
- R6: Rates above `CLK_HZ`/2 give pulses on consecutive cycles, and the count in R3 still holds.
- R7: The output is registered. With a rate M > 0 held from reset, `pulse_o` is 0 after the first clock edge following reset release and 1 after the second.
- R8: On each edge, if the accumulator is negative, `CLK_HZ` minus the present rate is added and the next `pulse_o` is 1. Otherwise the present rate is subtracted and the next `pulse_o` is 0. A change of `rate_i` therefore takes effect at the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, frequency `CLK_HZ` |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_i | input | RATE_W | Requested pulse rate in pulses per second |
| pulse_o | output | 1 | Registered pulse train |

## Verification
A wrong accumulator value cannot be seen directly. It appears at the ports as a pulse that arrives a cycle early or late, so a cycle-exact reference model catches it on the first clock edge where the wrong sign changes the wrap decision. A wrong wrap correction shifts every later pulse. Within one `CLK_HZ` window this shows up as a wrong pulse count and as intervals outside the floor/ceil pair. Faults that affect only rates above half the clock appear at the ports as the absence of back-to-back pulses.

// File: rtl/rate_pulse_pkg.sv
package rate_pulse_pkg;

  // Bits needed for a signed value spanning -(2**rate_w) .. clk_hz-1
  function automatic int acc_width(int clk_hz, int rate_w);
    int w;
    w = $clog2(clk_hz);
    if (rate_w > w) w = rate_w;
    return w + 1;
  endfunction

endpackage

// File: rtl/rpg_wrap_detect.sv
module rpg_wrap_detect #(
  parameter int ACC_W = 11
) (
  input  logic signed [ACC_W-1:0] acc_i,
  output logic                    wrap_o
);
  assign wrap_o = acc_i[ACC_W-1];
endmodule

// File: rtl/rpg_step_select.sv
module rpg_step_select #(
  parameter int CLK_HZ = 1000,
  parameter int RATE_W = 10,
  parameter int ACC_W  = 11
) (
  input  logic [RATE_W-1:0]       rate_i,
  input  logic                    wrap_i,
  output logic signed [ACC_W-1:0] step_o
);
  localparam int PAD = ACC_W - RATE_W;
  localparam logic signed [ACC_W-1:0] MOD = ACC_W'(CLK_HZ);

  logic signed [ACC_W-1:0] rate_sx;
  logic signed [ACC_W-1:0] neg_rate;
  logic signed [ACC_W-1:0] wrap_step;

  assign rate_sx   = $signed({{PAD{1'b0}}, rate_i});
  assign neg_rate  = -rate_sx;
  assign wrap_step = MOD - rate_sx;  // second adder: modulus minus rate

  always_comb begin
    if (wrap_i) step_o = wrap_step;
    else        step_o = neg_rate;
  end
endmodule

// File: rtl/rpg_accum.sv
module rpg_accum #(
  parameter int ACC_W = 11
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [ACC_W-1:0] step_i,
  output logic signed [ACC_W-1:0] acc_o
);
  logic signed [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_q + step_i;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/rpg_pulse_reg.sv
module rpg_pulse_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  output logic pulse_o
);
  logic pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= wrap_i;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/rate_pulse_gen.sv
module rate_pulse_gen #(
  parameter int CLK_HZ = 1000,
  parameter int RATE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  output logic              pulse_o
);
  import rate_pulse_pkg::*;

  localparam int ACC_W = acc_width(CLK_HZ, RATE_W);
  localparam int PAD   = ACC_W - RATE_W;
  localparam logic signed [ACC_W-1:0] MOD     = ACC_W'(CLK_HZ);
  localparam logic signed [ACC_W-1:0] NEG_LIM = ACC_W'(-(2 ** RATE_W));

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] step;
  logic                    wrap;

  rpg_wrap_detect #(.ACC_W(ACC_W)) u_wrap (
    .acc_i  (acc),
    .wrap_o (wrap)
  );

  rpg_step_select #(.CLK_HZ(CLK_HZ), .RATE_W(RATE_W), .ACC_W(ACC_W)) u_step (
    .rate_i (rate_i),
    .wrap_i (wrap),
    .step_o (step)
  );

  rpg_accum #(.ACC_W(ACC_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .acc_o  (acc)
  );

  rpg_pulse_reg u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wrap_i  (wrap),
    .pulse_o (pulse_o)
  );

  // ---------------- checks ----------------
  logic signed [ACC_W-1:0] rate_sx;
  logic                    armed_q;

  assign rate_sx = $signed({{PAD{1'b0}}, rate_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  initial begin
    assert_params_R3: assert (CLK_HZ >= 2 && RATE_W >= 1)
      else $error("illegal CLK_HZ/RATE_W parameters");
  end

  assert_rate_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rate_i) < CLK_HZ);

  assert_acc_bounds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc < MOD) && (acc >= NEG_LIM));

  assert_wrap_update_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && pulse_o) |-> acc == $past(acc) + MOD - $past(rate_sx));

  assert_plain_update_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !pulse_o) |-> acc == $past(acc) - $past(rate_sx));

  assert_zero_rate_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i == '0 && acc >= 0) |=> (acc >= 0 && !pulse_o));

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (acc == '0 && !pulse_o));

endmodule

// File: tb/rate_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module rate_pulse_gen_tb_top;
  localparam int N = 1000;
  localparam int W = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] rate_i = '0;
  logic         pulse_o;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  int acc_m;
  bit pulse_m;
  int cur_cycle;
  int win_cnt;
  int last_pulse;
  bit prev_pulse;
  bit seen_b2b;

  always #4 clk_i = ~clk_i;  // 125 MHz

  rate_pulse_gen #(.CLK_HZ(N), .RATE_W(W)) dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rate_i  (rate_i),
    .pulse_o (pulse_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)",
               req, what, act, exp, cur_cycle);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic do_reset(input int rate);
    @(negedge clk_i);
    rst_ni = 1'b0;
    rate_i = W'(rate);
    repeat (3) @(negedge clk_i);
    check(pulse_o === 1'b0, "R1", "pulse during reset", int'(pulse_o), 0);
    rst_ni = 1'b1;
    acc_m = 0; pulse_m = 0; cur_cycle = 0; win_cnt = 0;
    last_pulse = -1; prev_pulse = 0; seen_b2b = 0;
  endtask

  // one clock: model update, edge, compare away from the edge
  task automatic step(input bit stats);
    int m, ivl, lo, hi;
    m = int'(rate_i);
    pulse_m = (acc_m < 0);
    if (pulse_m) acc_m = acc_m + N;
    acc_m = acc_m - m;
    @(posedge clk_i);
    @(negedge clk_i);
    cur_cycle++;
    check(pulse_o === pulse_m, "R8", "pulse vs model", int'(pulse_o), int'(pulse_m));
    if (!stats) return;
    if (cur_cycle == 1) check(pulse_o === 1'b0, "R7", "pulse after 1st edge", int'(pulse_o), 0);
    if (cur_cycle == 2) check(pulse_o === (m > 0), "R7", "pulse after 2nd edge",
                              int'(pulse_o), int'(m > 0));
    if (pulse_o) begin
      win_cnt++;
      if (prev_pulse) seen_b2b = 1;
      if (m <= N / 2) check(!prev_pulse, "R2", "pulse wider than one cycle", 2, 1);
      if (last_pulse >= 0) begin
        ivl = cur_cycle - last_pulse;
        lo = N / m;
        hi = (N + m - 1) / m;
        check(ivl == lo || ivl == hi, "R4", "pulse interval", ivl, lo);
      end
      last_pulse = cur_cycle;
    end
    prev_pulse = pulse_o;
    if (cur_cycle % N == 0) begin
      if (m == 0) check(win_cnt == 0, "R5", "pulses at zero rate", win_cnt, 0);
      else        check(win_cnt == m, "R3", "pulses per window", win_cnt, m);
      win_cnt = 0;
    end
  endtask

  task automatic run_rate(input int m);
    do_reset(m);
    for (int i = 0; i < 2 * N; i++) step(1'b1);
    if (m > N / 2) check(seen_b2b, "R6", "back-to-back pulses seen", int'(seen_b2b), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    run_rate(0);    // R5
    run_rate(1);
    run_rate(3);
    run_rate(7);
    run_rate(250);
    run_rate(333);
    run_rate(499);
    run_rate(500);  // R2 boundary
    run_rate(501);  // R6
    run_rate(750);
    run_rate(999);  // R6 upper legal limit

    // R8: rate changes mid-run, tracked against the model each cycle
    do_reset(123);
    for (int i = 0; i < 137; i++) step(1'b0);
    rate_i = W'(777);
    for (int i = 0; i < 300; i++) step(1'b0);
    rate_i = W'(0);
    for (int i = 0; i < 50; i++) step(1'b0);
    rate_i = W'(500);
    for (int i = 0; i < 200; i++) step(1'b0);
    rate_i = W'(1);
    for (int i = 0; i < 40; i++) step(1'b0);

    summary();
    $finish;
  end
endmodule